// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block is the slave-side front end of a serial NOR flash model that answers only the identification commands. A host drives chip select, serial clock and serial data in, and the block shifts identification bytes back on serial data out. It accepts both clock idle levels. The clock may idle low (mode 0) or high (mode 3). In both cases the block samples the input on the rising edge and changes its output on the falling edge. A parameter selects the density of 16, 32 or 64 Mbit, and the density sets the device and capacity codes that are returned.

The first byte of every transaction is the opcode. Three opcodes return byte sequences built from one density-keyed set of codes. One opcode puts the block into a deep sleep. In that sleep only the wake opcode is obeyed. Any other opcode leaves the data output undriven for the whole transaction. The SPI pins are oversampled by the system clock through a short synchronizer, so the serial clock must be several times slower than the system clock.

Top module: `spi_id_responder`

## Requirements
- R1: Transactions work with the serial clock idle low (mode 0) and idle high (mode 3). Input bits are taken on rising clock edges, and output bits are updated only after falling clock edges.
- R2: All bytes are shifted MSB first. A new output bit is presented after each falling edge of the data phase, and the output bit holds its value between falling edges.
- R3: Opcode 9Fh returns 01h, then 40h, then the capacity code, starting with the first falling edge after the opcode. The capacity code is 15h for 16 Mbit, 16h for 32 Mbit and 17h for 64 Mbit.
- R4: Opcode 90h is followed by three address bytes. After them the block returns 01h and then the device code, which is 14h for 16 Mbit, 15h for 32 Mbit and 16h for 64 Mbit. If bit 0 of the last address byte is 1, the two bytes come out in the opposite order.
- R5: Opcode ABh is followed by three dummy bytes. After them the block returns the device code. It also ends the sleep state as soon as its opcode byte is complete.
- R6: Opcode B9h, once its eighth bit is received and chip select is raised afterwards, enters the sleep state. While asleep, every opcode except ABh is ignored and the output stays undriven.
- R7: If the clock keeps running past the end of a sequence, the sequence starts again from its first byte.
- R8: Any opcode other than 9Fh, 90h, ABh and B9h leaves the output undriven for the whole transaction. The output is also undriven while the opcode, address and dummy bits are being received.
- R9: Raising chip select stops any transaction and releases the output. The next transaction starts again from the opcode. A B9h that is cut off before its eighth bit does not cause sleep.
- R10: After reset the output is undriven and the block is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, high impedance when not driven |
| spi_miso_oe | output | 1 | High while spi_miso is driven |

## Verification
The hardest situations to reach from the pins are the two that span transactions. The first is the sleep state, which begins only when chip select rises after a complete B9h and which is invisible except as silence. The second is the wrap-around of a sequence when the host keeps clocking. The stimulus sends B9h and then probes with 9Fh and a full 90h frame that must stay silent. It then wakes the block with ABh and confirms that 9Fh answers again. A B9h cut off after four bits must leave the block awake. Reads longer than a sequence are clocked in both modes to catch the restart at the first byte.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

  typedef enum logic [1:0] {PH_OPC, PH_HDR, PH_DATA, PH_IDLE} phase_e;
  typedef enum logic [1:0] {SQ_JEDEC, SQ_MFDV, SQ_SIG} seq_e;

  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_MFDV  = 8'h90;
  localparam logic [7:0] OP_WAKE  = 8'hAB;
  localparam logic [7:0] OP_SLEEP = 8'hB9;

  localparam logic [7:0] MFR_CODE  = 8'h01;
  localparam logic [7:0] TYPE_CODE = 8'h40;

  // device code grows by one per density doubling, starting at 14h for 16 Mbit
  function automatic logic [7:0] dev_code(input int mbit);
    return 8'h14 + 8'($clog2(mbit) - 4);
  endfunction

  function automatic logic [7:0] cap_code(input int mbit);
    return dev_code(mbit) + 8'h01;
  endfunction

  function automatic logic [4:0] seq_bits(input seq_e k);
    case (k)
      SQ_JEDEC: return 5'd24;
      SQ_MFDV:  return 5'd16;
      default:  return 5'd8;
    endcase
  endfunction

  function automatic logic [7:0] seq_byte(input seq_e k, input logic swap,
                                          input logic [1:0] idx, input int mbit);
    case (k)
      SQ_JEDEC: begin
        if (idx == 2'd0)      return MFR_CODE;
        else if (idx == 2'd1) return TYPE_CODE;
        else                  return cap_code(mbit);
      end
      SQ_MFDV: return (idx[0] ^ swap) ? dev_code(mbit) : MFR_CODE;
      default: return dev_code(mbit);
    endcase
  endfunction

endpackage

// File: rtl/spi_id_sync.sv
module spi_id_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic cs_n_o,
  output logic mosi_o,
  output logic rise_o,
  output logic fall_o,
  output logic cs_rise_o
);
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] cs_pipe, sck_pipe, mosi_pipe;
  logic             sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe   <= '1;
      sck_pipe  <= '0;
      mosi_pipe <= '0;
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
    end else begin
      cs_pipe   <= {cs_pipe[DEPTH-2:0], cs_n_i};
      sck_pipe  <= {sck_pipe[DEPTH-2:0], sck_i};
      mosi_pipe <= {mosi_pipe[DEPTH-2:0], mosi_i};
      sck_q     <= sck_pipe[DEPTH-1];
      cs_q      <= cs_pipe[DEPTH-1];
    end
  end

  assign cs_n_o    = cs_pipe[DEPTH-1];
  assign mosi_o    = mosi_pipe[DEPTH-1];
  assign rise_o    = sck_pipe[DEPTH-1] & ~sck_q;
  assign fall_o    = ~sck_pipe[DEPTH-1] & sck_q;
  assign cs_rise_o = cs_pipe[DEPTH-1] & ~cs_q;

endmodule

// File: rtl/spi_id_seq.sv
module spi_id_seq
  import spi_id_pkg::*;
#(
  parameter int DENSITY_MBIT = 64,
  parameter int CNT_W        = 5
) (
  input  seq_e             kind,
  input  logic             swap,
  input  logic [CNT_W-1:0] bit_idx,
  output logic             out_bit
);
  logic [7:0] cur_byte;
  logic [2:0] bit_pos;

  always_comb begin
    cur_byte = seq_byte(kind, swap, bit_idx[4:3], DENSITY_MBIT);
    bit_pos  = 3'd7 - bit_idx[2:0];
    out_bit  = cur_byte[bit_pos];
  end

endmodule

// File: rtl/spi_id_ctrl.sv
module spi_id_ctrl
  import spi_id_pkg::*;
#(
  parameter int HDR_BITS = 24,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic             rise,
  input  logic             fall,
  input  logic             cs_rise,
  input  logic             out_bit,
  output seq_e             kind,
  output logic             swap,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             miso_d,
  output logic             miso_oe,
  output logic             pd
);
  phase_e     phase;
  logic [6:0] shreg;
  logic       sleep_arm;
  logic [7:0] op_word;
  logic       op_done, hdr_done, seq_wrap;

  assign op_word  = {shreg, mosi};
  assign op_done  = !cs_n && rise && (phase == PH_OPC) && (bit_cnt == CNT_W'(7));
  assign hdr_done = !cs_n && rise && (phase == PH_HDR) && (bit_cnt == CNT_W'(HDR_BITS - 1));
  assign seq_wrap = (bit_cnt == CNT_W'(seq_bits(kind) - 5'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OPC;
      shreg     <= '0;
      bit_cnt   <= '0;
      kind      <= SQ_JEDEC;
      swap      <= 1'b0;
      miso_d    <= 1'b0;
      miso_oe   <= 1'b0;
      pd        <= 1'b0;
      sleep_arm <= 1'b0;
    end else if (cs_n) begin
      phase     <= PH_OPC;
      shreg     <= '0;
      bit_cnt   <= '0;
      miso_oe   <= 1'b0;
      sleep_arm <= 1'b0;
      if (cs_rise && sleep_arm) pd <= 1'b1;
    end else begin
      case (phase)
        PH_OPC: if (rise) begin
          shreg <= op_word[6:0];
          if (op_done) begin
            bit_cnt <= '0;
            if (op_word == OP_WAKE) begin
              kind  <= SQ_SIG;
              phase <= PH_HDR;
              pd    <= 1'b0;
            end else if (pd) begin
              phase <= PH_IDLE;
            end else begin
              case (op_word)
                OP_JEDEC: begin kind <= SQ_JEDEC; phase <= PH_DATA; end
                OP_MFDV:  begin kind <= SQ_MFDV;  phase <= PH_HDR;  end
                OP_SLEEP: begin sleep_arm <= 1'b1; phase <= PH_IDLE; end
                default:  phase <= PH_IDLE;
              endcase
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        PH_HDR: if (rise) begin
          if (hdr_done) begin
            bit_cnt <= '0;
            phase   <= PH_DATA;
            swap    <= (kind == SQ_MFDV) && mosi;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        PH_DATA: begin
          if (rise) bit_cnt <= seq_wrap ? '0 : bit_cnt + 1'b1;
          if (fall) begin
            miso_d  <= out_bit;
            miso_oe <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
  import spi_id_pkg::*;
#(
  parameter int DENSITY_MBIT = 64,
  parameter int SYNC_STAGES  = 2,
  parameter int ADDR_BYTES   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int HDR_BITS = 8 * ADDR_BYTES;
  localparam int MAX_BITS = (HDR_BITS > 24) ? HDR_BITS : 24;
  localparam int CNT_W    = $clog2(MAX_BITS);

  logic             cs_n_s, mosi_s;
  logic             rise_evt, fall_evt, cs_rise_evt;
  seq_e             kind;
  logic             swap, out_bit, miso_d, pd_q;
  logic [CNT_W-1:0] bit_cnt;

  spi_id_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .cs_n_o(cs_n_s), .mosi_o(mosi_s),
    .rise_o(rise_evt), .fall_o(fall_evt), .cs_rise_o(cs_rise_evt)
  );

  spi_id_ctrl #(.HDR_BITS(HDR_BITS), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cs_n(cs_n_s), .mosi(mosi_s),
    .rise(rise_evt), .fall(fall_evt), .cs_rise(cs_rise_evt),
    .out_bit(out_bit),
    .kind(kind), .swap(swap), .bit_cnt(bit_cnt),
    .miso_d(miso_d), .miso_oe(spi_miso_oe), .pd(pd_q)
  );

  spi_id_seq #(.DENSITY_MBIT(DENSITY_MBIT), .CNT_W(CNT_W)) seq_i (
    .kind(kind), .swap(swap), .bit_idx(bit_cnt), .out_bit(out_bit)
  );

  assign spi_miso = spi_miso_oe ? miso_d : 1'bz;

endmodule

// File: rtl/spi_id_responder_chk.sv
module spi_id_responder_chk #(
  parameter int CNT_W   = 5,
  parameter int MAX_CNT = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_s,
  input logic             fall_evt,
  input logic             cs_rise_evt,
  input logic             pd_q,
  input logic             miso_oe,
  input logic             miso_d,
  input logic [CNT_W-1:0] bit_cnt
);

  AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !miso_oe); // R9

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(fall_evt)); // R1

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && !$past(fall_evt)) |-> $stable(miso_d)); // R2

  AST_SILENT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> !miso_oe); // R6

  AST_SLEEP_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(cs_rise_evt)); // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(MAX_CNT)); // R7

endmodule

bind spi_id_responder spi_id_responder_chk #(.CNT_W(CNT_W), .MAX_CNT(MAX_BITS - 1)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .fall_evt(fall_evt),
  .cs_rise_evt(cs_rise_evt), .pd_q(pd_q), .miso_oe(spi_miso_oe),
  .miso_d(miso_d), .bit_cnt(bit_cnt)
);

// File: tb/spi_id_responder_tb.sv
module spi_id_responder_tb_top;
  localparam int DENSITY = 64;
  localparam int HALF    = 8;
  localparam logic [7:0] DEV = (DENSITY == 16) ? 8'h14 : (DENSITY == 32) ? 8'h15 : 8'h16;
  localparam logic [7:0] CAP = DEV + 8'h01;

  typedef struct packed {
    logic        mode;
    logic [7:0]  op;
    logic        lsb;
    logic [2:0]  nrd;
    logic        quiet;
    logic [47:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h9F, 1'b0, 3'd3, 1'b0, {8'h01, 8'h40, CAP, 24'h0}},
    '{1'b1, 8'h9F, 1'b0, 3'd3, 1'b0, {8'h01, 8'h40, CAP, 24'h0}},
    '{1'b0, 8'h90, 1'b0, 3'd2, 1'b0, {8'h01, DEV, 32'h0}},
    '{1'b1, 8'h90, 1'b1, 3'd2, 1'b0, {DEV, 8'h01, 32'h0}},
    '{1'b0, 8'hAB, 1'b0, 3'd1, 1'b0, {DEV, 40'h0}},
    '{1'b1, 8'hAB, 1'b1, 3'd1, 1'b0, {DEV, 40'h0}},
    '{1'b0, 8'h9F, 1'b0, 3'd6, 1'b0, {8'h01, 8'h40, CAP, 8'h01, 8'h40, CAP}},
    '{1'b1, 8'h90, 1'b1, 3'd5, 1'b0, {DEV, 8'h01, DEV, 8'h01, DEV, 8'h00}},
    '{1'b0, 8'h03, 1'b0, 3'd3, 1'b1, 48'h0},
    '{1'b1, 8'h05, 1'b0, 3'd3, 1'b1, 48'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  wire  miso;
  logic miso_oe;
  int   n_checks = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  spi_id_responder #(.DENSITY_MBIT(DENSITY)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_txn(input logic mode);
    sck = mode;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_txn(input logic mode);
    if (!mode) begin sck = 1'b0; wait_clk(HALF); end
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  // sends the top n bits of tx; samples miso at the end of each low half
  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx, output int oe_cnt);
    rx = '0;
    oe_cnt = 0;
    for (int i = 7; i > 7 - n; i--) begin
      sck  = 1'b0;
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = (miso === 1'b1);
      oe_cnt += int'(miso_oe);
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic do_txn(input logic mode, input logic [7:0] op, input logic lsb, input int nrd,
                        input logic quiet, input logic [47:0] exp, input string tag);
    logic [7:0] rx;
    int oe;
    begin_txn(mode);
    xbits(op, 8, rx, oe);
    chk({tag, " R8"}, "oe during opcode", oe, 0);
    if (op == 8'h90 || op == 8'hAB) begin
      for (int h = 0; h < 3; h++) begin
        xbits((h == 2) ? {7'b0, lsb} : 8'h00, 8, rx, oe);
        chk({tag, " R8"}, "oe during header", oe, 0);
      end
    end
    for (int b = 0; b < nrd; b++) begin
      xbits(8'h00, 8, rx, oe);
      if (quiet) chk(tag, "oe while ignored", oe, 0);
      else begin
        chk({tag, " R2"}, "data byte", {24'h0, rx}, {24'h0, exp[47 - 8*b -: 8]});
        chk(tag, "oe bits in byte", oe, 8);
      end
    end
    end_txn(mode);
    chk({tag, " R9"}, "oe after deselect", {31'h0, miso_oe}, 0);
  endtask

  function automatic string tag_of(input vec_t v);
    string s;
    if (v.quiet)            s = "R8";
    else if (v.op == 8'h9F) s = (v.nrd > 3) ? "R3 R7" : "R3";
    else if (v.op == 8'h90) s = (v.nrd > 2) ? "R4 R7" : "R4";
    else                    s = "R5";
    return v.mode ? {"R1 ", s} : s;
  endfunction

  initial begin
    logic [7:0] rx;
    int oe;
    wait_clk(4);
    chk("R10", "oe in reset", {31'h0, miso_oe}, 0);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R10", "oe after reset", {31'h0, miso_oe}, 0);

    for (int v = 0; v < NV; v++)
      do_txn(VECS[v].mode, VECS[v].op, VECS[v].lsb, int'(VECS[v].nrd),
             VECS[v].quiet, VECS[v].exp, tag_of(VECS[v]));

    // abort after one data byte, then a fresh read starts from the first byte
    do_txn(1'b0, 8'h9F, 1'b0, 1, 1'b0, {8'h01, 40'h0}, "R9");
    do_txn(1'b1, 8'h9F, 1'b0, 2, 1'b0, {8'h01, 8'h40, 32'h0}, "R9");

    // sleep opcode cut after four bits must not cause sleep
    begin_txn(1'b0);
    xbits(8'hB9, 4, rx, oe);
    end_txn(1'b0);
    do_txn(1'b0, 8'h9F, 1'b0, 3, 1'b0, {8'h01, 8'h40, CAP, 24'h0}, "R9");

    // full sleep, probes ignored, wake, normal answer again
    do_txn(1'b0, 8'hB9, 1'b0, 1, 1'b1, 48'h0, "R6");
    do_txn(1'b0, 8'h9F, 1'b0, 3, 1'b1, 48'h0, "R6");
    do_txn(1'b1, 8'h90, 1'b0, 2, 1'b1, 48'h0, "R6");
    do_txn(1'b1, 8'hAB, 1'b0, 2, 1'b0, {DEV, DEV, 32'h0}, "R5 R7");
    do_txn(1'b0, 8'h9F, 1'b0, 3, 1'b0, {8'h01, 8'h40, CAP, 24'h0}, "R5");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule